// File: doc/BRIEF.md
# Watermark Oscillator Sequence Controller

This block turns a user challenge into an activation pattern for one of a bank of watermark oscillators. A 32-bit linear feedback shift register is seeded from an on-chip identifier joined with the lower half of the challenge. The upper half of the challenge says how many clock cycles the register advances before it stops. The low 24 bits of the final register value form the sequence word. That word names an oscillator, carries a 16-bit lookup-table truth table and gives a 4-bit divisor.

Once the sequence is ready, the block presents the select and truth table on a single-strobe write port. It then drives the chosen oscillator's enable with a square wave at 50 percent duty. The wave is divided from the system clock. For the whole test, from start until stop, a pause request is held so that the protected logic's clock can be gated and its state kept. A stop input ends the test at once.

Top module: `wm_seq_ctrl`

## Requirements
- R1: After reset, busy, done, cfg_wr and pause_req are 0 and osc_en is all zeros.
- R2: The register is loaded with {chip_id, challenge[15:0]} (chip_id in the upper 16 bits). A load value of zero is replaced by 32'h0000_0001, so a zero seed gives the same sequence as a seed of 1.
- R3: Each advance is a right-shifting Galois step: next = (s >> 1) ^ (s[0] ? 32'h8020_0003 : 0). The register advances exactly N = challenge[31:16] times. If start is sampled at edge k, busy is high from edge k, and done first goes high after edge k+N+1.
- R4: seq_word is the low 24 bits of the register after the N advances. osc_sel = seq_word[23:20], lut_init = seq_word[19:4] and div_val = seq_word[3:0].
- R5: done, seq_word and the decoded fields stay unchanged from done until the next accepted start, including across stop. A start that arrives while busy is ignored.
- R6: cfg_wr is a single-cycle strobe that coincides with the first cycle of done, with osc_sel and lut_init valid.
- R7: pause_req is high from the cycle after an accepted start until the cycle after stop, and it is always high while busy.
- R8: From the first cycle of done, osc_en bit osc_sel is high for H = (div_val+1)*PRESCALE cycles, then low for H cycles, and this repeats. All other osc_en bits stay 0.
- R9: stop sampled at an edge forces osc_en to zero and pause_req low after that edge. A stop during the advance phase aborts it and leaves done at 0.
- R10: A start accepted while the oscillator is active restarts the derivation. done clears and osc_en goes to zero while busy, and pause_req stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chip_id | input | 16 | On-chip identifier, upper half of the seed |
| challenge | input | 32 | User challenge: [15:0] seed part, [31:16] advance count |
| start | input | 1 | Begin a derivation (ignored while busy) |
| stop | input | 1 | End the test, drop enable and pause |
| busy | output | 1 | Register is advancing |
| done | output | 1 | Sequence word is valid |
| seq_word | output | 24 | Captured sequence word |
| osc_sel | output | 4 | Selected oscillator index |
| lut_init | output | 16 | Truth table for the selected lookup table |
| div_val | output | 4 | Divider field |
| cfg_wr | output | 1 | Write strobe for osc_sel and lut_init |
| osc_en | output | 16 | One-hot gated enable for the oscillator bank |
| pause_req | output | 1 | Clock-gate request for the protected design |

## Verification
The bench keeps the default widths and sets PRESCALE to 2. With that setting even the largest divisor gives a half period of only 32 cycles, so several full enable periods fit in each case. Advance counts are mostly kept below 50, with directed cases at zero and at the 65535 maximum. This lets the count check cover both ends of the counter. Zero and unit seeds are run side by side to show the lock-up substitution.

// File: rtl/wm_seq_pkg.sv
package wm_seq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RUN    = 2'd1,
        ST_ACTIVE = 2'd2
    } wm_state_e;
endpackage

// File: rtl/wm_lfsr.sv
module wm_lfsr #(
    parameter int            W     = 32,
    parameter int            OUT_W = 24,
    parameter logic [W-1:0]  TAPS  = 32'h8020_0003,
    parameter logic [W-1:0]  ZSUB  = 32'h0000_0001
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [W-1:0]     seed,
    input  logic             step,
    output logic [OUT_W-1:0] low_bits
);
    logic [W-1:0] state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (load) begin
            state_d = (seed == '0) ? ZSUB : seed;
        end else if (step) begin
            state_d = (state_q >> 1) ^ (state_q[0] ? TAPS : '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ZSUB;
        else        state_q <= state_d;
    end

    assign low_bits = state_q[OUT_W-1:0];
endmodule

// File: rtl/wm_field_decode.sv
module wm_field_decode #(
    parameter int SEL_W  = 4,
    parameter int INIT_W = 16,
    parameter int DIV_W  = 4,
    localparam int SEQ_W   = SEL_W + INIT_W + DIV_W,
    localparam int NUM_OSC = 1 << SEL_W
) (
    input  logic [SEQ_W-1:0]   seq,
    output logic [SEL_W-1:0]   sel,
    output logic [INIT_W-1:0]  init,
    output logic [DIV_W-1:0]   div,
    output logic [NUM_OSC-1:0] sel_onehot
);
    assign sel  = seq[SEQ_W-1 -: SEL_W];
    assign init = seq[DIV_W +: INIT_W];
    assign div  = seq[DIV_W-1:0];

    for (genvar g = 0; g < NUM_OSC; g++) begin : g_hot
        assign sel_onehot[g] = (sel == SEL_W'(g));
    end
endmodule

// File: rtl/wm_en_divider.sv
module wm_en_divider #(
    parameter int DIV_W    = 4,
    parameter int PRESCALE = 4,
    localparam int CNT_W   = $clog2((1 << DIV_W) * PRESCALE + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] divisor,
    output logic             phase
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             ph;
    } div_t;

    div_t             d, q;
    logic [CNT_W-1:0] half_m1;

    always_comb begin
        half_m1 = CNT_W'((32'(divisor) + 32'd1) * PRESCALE - 1);
        d = q;
        if (!run) begin
            d.cnt = '0;
            d.ph  = 1'b1;
        end else if (q.cnt == half_m1) begin
            d.cnt = '0;
            d.ph  = ~q.ph;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{cnt: '0, ph: 1'b1};
        else        q <= d;
    end

    assign phase = q.ph;
endmodule

// File: rtl/wm_seq_ctrl.sv
module wm_seq_ctrl
    import wm_seq_pkg::*;
#(
    parameter int ID_W        = 16,
    parameter int CHAL_W      = 32,
    parameter int SEED_CHAL_W = 16,
    parameter int SEL_W       = 4,
    parameter int INIT_W      = 16,
    parameter int DIV_W       = 4,
    parameter int PRESCALE    = 4,
    localparam int LFSR_W  = ID_W + SEED_CHAL_W,
    localparam int RUN_W   = CHAL_W - SEED_CHAL_W,
    localparam int SEQ_W   = SEL_W + INIT_W + DIV_W,
    localparam int NUM_OSC = 1 << SEL_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ID_W-1:0]    chip_id,
    input  logic [CHAL_W-1:0]  challenge,
    input  logic               start,
    input  logic               stop,
    output logic               busy,
    output logic               done,
    output logic [SEQ_W-1:0]   seq_word,
    output logic [SEL_W-1:0]   osc_sel,
    output logic [INIT_W-1:0]  lut_init,
    output logic [DIV_W-1:0]   div_val,
    output logic               cfg_wr,
    output logic [NUM_OSC-1:0] osc_en,
    output logic               pause_req
);
    typedef struct packed {
        wm_state_e          st;
        logic [RUN_W-1:0]   cnt;
        logic [SEQ_W-1:0]   seq;
        logic               done;
        logic               wr;
    } ctl_t;

    ctl_t               d, q;
    logic               lfsr_load, lfsr_step;
    logic [SEQ_W-1:0]   lfsr_low;
    logic [NUM_OSC-1:0] sel_hot;
    logic               en_phase;
    logic               active;

    always_comb begin
        d         = q;
        d.wr      = 1'b0;
        lfsr_load = 1'b0;
        lfsr_step = 1'b0;
        if (stop) begin
            d.st = ST_IDLE;
        end else begin
            case (q.st)
                ST_RUN: begin
                    if (q.cnt == '0) begin
                        d.seq  = lfsr_low;
                        d.done = 1'b1;
                        d.wr   = 1'b1;
                        d.st   = ST_ACTIVE;
                    end else begin
                        lfsr_step = 1'b1;
                        d.cnt     = q.cnt - 1'b1;
                    end
                end
                default: begin
                    if (start) begin
                        d.st      = ST_RUN;
                        d.cnt     = challenge[CHAL_W-1:SEED_CHAL_W];
                        d.done    = 1'b0;
                        lfsr_load = 1'b1;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_IDLE, cnt: '0, seq: '0, done: 1'b0, wr: 1'b0};
        else        q <= d;
    end

    wm_lfsr #(
        .W(LFSR_W), .OUT_W(SEQ_W)
    ) u_lfsr (
        .clk(clk), .rst_n(rst_n), .load(lfsr_load),
        .seed({chip_id, challenge[SEED_CHAL_W-1:0]}),
        .step(lfsr_step), .low_bits(lfsr_low)
    );

    wm_field_decode #(
        .SEL_W(SEL_W), .INIT_W(INIT_W), .DIV_W(DIV_W)
    ) u_dec (
        .seq(q.seq), .sel(osc_sel), .init(lut_init), .div(div_val),
        .sel_onehot(sel_hot)
    );

    assign active = (q.st == ST_ACTIVE);

    wm_en_divider #(
        .DIV_W(DIV_W), .PRESCALE(PRESCALE)
    ) u_div (
        .clk(clk), .rst_n(rst_n), .run(active), .divisor(div_val),
        .phase(en_phase)
    );

    assign osc_en    = (active && en_phase) ? sel_hot : '0;
    assign busy      = (q.st == ST_RUN);
    assign done      = q.done;
    assign seq_word  = q.seq;
    assign cfg_wr    = q.wr;
    assign pause_req = (q.st != ST_IDLE);
endmodule

// File: rtl/wm_seq_ctrl_chk.sv
module wm_seq_ctrl_chk #(
    parameter int SEL_W   = 4,
    parameter int SEQ_W   = 24,
    parameter int NUM_OSC = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic               stop,
    input logic               busy,
    input logic               done,
    input logic               cfg_wr,
    input logic               pause_req,
    input logic [NUM_OSC-1:0] osc_en,
    input logic [SEL_W-1:0]   osc_sel,
    input logic [SEQ_W-1:0]   seq_word
);
    assert_busy_pauses_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> pause_req);

    assert_stop_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> (!pause_req && osc_en == '0));

    assert_one_osc_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(osc_en));

    assert_en_selected_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (osc_en != '0) |-> (done && pause_req && !busy && osc_en[osc_sel]));

    assert_hold_fields_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(seq_word)));

    assert_wr_first_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |-> $rose(done));

    assert_wr_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> !cfg_wr);
endmodule

bind wm_seq_ctrl wm_seq_ctrl_chk #(
    .SEL_W(SEL_W), .SEQ_W(SEQ_W), .NUM_OSC(NUM_OSC)
) u_chk (.*);

// File: tb/wm_seq_ctrl_tb_top.sv
`timescale 1ns/1ps
module wm_seq_ctrl_tb_top;
    localparam int PRESC = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] chip_id = '0;
    logic [31:0] challenge = '0;
    logic        start = 1'b0, stop = 1'b0;
    logic        busy, done, cfg_wr, pause_req;
    logic [23:0] seq_word;
    logic [3:0]  osc_sel, div_val;
    logic [15:0] lut_init, osc_en;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    wm_seq_ctrl #(.PRESCALE(PRESC)) dut_i (
        .clk(clk), .rst_n(rst_n), .chip_id(chip_id), .challenge(challenge),
        .start(start), .stop(stop), .busy(busy), .done(done),
        .seq_word(seq_word), .osc_sel(osc_sel), .lut_init(lut_init),
        .div_val(div_val), .cfg_wr(cfg_wr), .osc_en(osc_en),
        .pause_req(pause_req)
    );

    function automatic logic [23:0] exp_seq(input logic [15:0] id, input logic [31:0] ch);
        logic [31:0] s;
        s = {id, ch[15:0]};
        if (s == 32'h0) s = 32'h1;
        for (int i = 0; i < int'(ch[31:16]); i++)
            s = (s >> 1) ^ (s[0] ? 32'h8020_0003 : 32'h0);
        return s[23:0];
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic kick(input logic [15:0] id, input logic [31:0] ch);
        @(negedge clk);
        chip_id = id; challenge = ch; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(output int c);
        c = 0;
        while (!done && c < 70000) begin
            @(negedge clk);
            c++;
        end
    endtask

    task automatic stop_pulse();
        @(negedge clk); stop = 1'b1;
        @(negedge clk); stop = 1'b0;
    endtask

    task automatic full_case(input logic [15:0] id, input logic [31:0] ch);
        logic [23:0] e;
        logic [15:0] hot;
        int c, half, bad;
        e = exp_seq(id, ch);
        kick(id, ch);
        chk("R3", "busy after start", 32'(busy), 1);
        chk("R7", "pause after start", 32'(pause_req), 1);
        wait_done(c);
        chk("R3", "advance cycles", c, int'(ch[31:16]) + 1);
        chk("R2", "sequence word", 32'(seq_word), 32'(e));
        chk("R4", "fields", {osc_sel, lut_init, div_val}, {e[23:20], e[19:4], e[3:0]});
        chk("R6", "write strobe", 32'(cfg_wr), 1);
        hot  = 16'(1) << e[23:20];
        half = (int'(e[3:0]) + 1) * PRESC;
        bad  = 0;
        chk("R8", "enable at done", 32'(osc_en), 32'(hot));
        for (int t = 1; t < 4 * half; t++) begin
            @(negedge clk);
            if (osc_en !== ((((t / half) % 2) == 0) ? hot : 16'h0)) bad++;
            if (t == 1) chk("R6", "strobe single", 32'(cfg_wr), 0);
        end
        chk("R8", "enable waveform mismatches", bad, 0);
        stop_pulse();
        chk("R9", "enable after stop", 32'(osc_en), 0);
        chk("R9", "pause after stop", 32'(pause_req), 0);
        chk("R5", "done and word kept after stop", {7'h0, done, seq_word}, {8'h01, e});
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int c, c2;
        logic [23:0] e1;
        process::self().srandom(32'd1234);
        repeat (3) @(negedge clk);
        chk("R1", "outputs in reset", {busy, done, cfg_wr, pause_req, osc_en}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "outputs after reset", {busy, done, cfg_wr, pause_req, osc_en}, 0);

        // R2 zero seed behaves as seed 1
        full_case(16'h0000, 32'h0003_0000);
        full_case(16'h0000, 32'h0003_0001);
        // R3 zero advances
        full_case(16'hBEEF, 32'h0000_1234);
        // random cases
        for (int i = 0; i < 10; i++)
            full_case(16'($urandom), {16'($urandom % 50), 16'($urandom)});
        // R3 maximum advance count
        full_case(16'h5A5A, 32'hFFFF_C3C3);

        // R5 start while busy is ignored
        e1 = exp_seq(16'h1357, 32'h000A_2468);
        kick(16'h1357, 32'h000A_2468);
        repeat (3) @(negedge clk);
        chip_id = 16'hFFFF; challenge = 32'h0002_0F0F; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(c2);
        chk("R5", "cycles with ignored start", 4 + c2, 11);
        chk("R5", "word with ignored start", 32'(seq_word), 32'(e1));

        // R10 restart from active
        kick(16'h2468, 32'h0007_1111);
        chk("R10", "busy on restart", 32'(busy), 1);
        chk("R10", "done cleared", 32'(done), 0);
        chk("R10", "enable off while busy", 32'(osc_en), 0);
        chk("R10", "pause held", 32'(pause_req), 1);
        wait_done(c);
        chk("R10", "restart cycles", c, 8);
        chk("R10", "restart word", 32'(seq_word), 32'(exp_seq(16'h2468, 32'h0007_1111)));
        stop_pulse();

        // R9 stop during advance
        kick(16'h0F0F, 32'h0014_7777);
        repeat (5) @(negedge clk);
        stop_pulse();
        chk("R9", "abort state", {busy, done, pause_req}, 0);
        repeat (30) @(negedge clk);
        chk("R9", "no done after abort", {done, cfg_wr, osc_en}, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule